// File: doc/BRIEF.md
# UART Interrupt and Wake Request Combiner

This block sits beside a UART transmitter and receiver and turns their status events into requests for the rest of the chip. Each event arrives as a one-cycle set pulse and is held in a sticky flag until software writes a one to the matching clear strobe. Each flag is then masked by its own enable. The enabled flags produce one registered interrupt line, a registered wake line that brings the processor out of a low-power wait state, and two registered DMA request lines.

The transmit-empty and receive-full events can be sent to DMA instead of the interrupt line, one select bit for each. The block also contains the receive-line edge detector. It passes the serial input through a two-flop synchronizer that resets to the idle level. It then looks for an active edge whose direction is set by a polarity bit. In two-wire mode it sets the sticky edge flag. All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Source indices, which also give the bit positions in every 16-bit vector: 0 transmit empty, 1 transmit complete, 2 line idle, 3 receive full, 4 receive edge, 5 overrun, 6 noise, 7 framing, 8 parity, 9 wait time, 10 character wait time, 11 block wait time, 12 initial character, 13 transmit threshold, 14 receive threshold, 15 guard time violation.

Top module: `uart_irq_wake`

## Requirements
- R1: While reset is asserted and right after it is released, `flags`, `irq`, `wake`, `tx_dma_req` and `rx_dma_req` are all 0.
- R2: A 1 on `flag_set[i]` sets `flags[i]` at the next clock edge. The flag stays set until it is cleared. When set and clear hit the same bit in the same cycle, the flag stays set.
- R3: A 1 on `flag_clr[i]` with no set on that bit clears `flags[i]` at the next edge. Other flags are not changed.
- R4: `irq` is a register. It goes high one clock after an enabled flag that is not steered to DMA becomes set, and it falls one clock after the last such flag clears.
- R5: With `tx_dma_sel`=0, an enabled flag 0 drives `irq`. With `tx_dma_sel`=1, it drives `tx_dma_req` (registered, same latency as `irq`) and does not contribute to `irq`.
- R6: With `rx_dma_sel`=0, an enabled flag 3 drives `irq`. With `rx_dma_sel`=1, it drives `rx_dma_req` and does not contribute to `irq`.
- R7: `wake` is high one clock after any enabled flag is set, whether or not that flag is steered to DMA.
- R8: `edge_pol`=0 detects falling edges and 1 detects rising edges on `rxd`. Flag 4 sets on the third clock edge after `rxd` changes.
- R9: While `two_wire` is 0, no line activity sets flag 4.
- R10: An edge counts only if the synchronized line was at the deasserted level (1 for falling, 0 for rising) on the cycle before the asserted level. A line that already sits at the asserted level never sets flag 4.
- R11: The bit of `flag_set` at index 4 has no effect. Only the edge detector sets flag 4.
- R12: A set flag whose enable is 0 drives none of `irq`, `wake` or the DMA requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_set | input | 16 | One-cycle set pulses from the UART datapath, by source index |
| flag_clr | input | 16 | Write-one-to-clear strobes, by source index |
| flag_en | input | 16 | Enable for each source |
| tx_dma_sel | input | 1 | Sends transmit-empty to DMA instead of the interrupt line |
| rx_dma_sel | input | 1 | Sends receive-full to DMA instead of the interrupt line |
| edge_pol | input | 1 | Edge polarity: 0 falling, 1 rising |
| two_wire | input | 1 | Two-wire mode; the edge flag can be set only while this is 1 |
| rxd | input | 1 | Asynchronous serial receive line |
| flags | output | 16 | Sticky status flags |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Registered wake request |
| tx_dma_req | output | 1 | Registered transmit DMA request |
| rx_dma_req | output | 1 | Registered receive DMA request |

## Verification
The flag and request path is driven three ways: with a single enabled source, with several sources at once where only one is cleared, and with a source that is set but not enabled. Together these separate set-over-clear priority, clearing of one bit only, and masking. The two steerable sources are flipped between DMA and interrupt while their flags stay set, which shows the request moving from one line to the other while `wake` stays up. The edge detector sees falling and rising transitions under both polarities, a line already at the asserted level when the polarity changes, line activity with two-wire mode off, and a direct set pulse on the edge bit. Each check samples at the exact cycle the synchronizer latency predicts.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC     = 16;
  localparam int SYNC_DEPTH  = 2;

  // Source indices; these positions are shared by every flag vector.
  localparam int SRC_TX_EMPTY   = 0;
  localparam int SRC_TX_DONE    = 1;
  localparam int SRC_IDLE       = 2;
  localparam int SRC_RX_FULL    = 3;
  localparam int SRC_RX_EDGE    = 4;
  localparam int SRC_OVERRUN    = 5;
  localparam int SRC_NOISE      = 6;
  localparam int SRC_FRAMING    = 7;
  localparam int SRC_PARITY     = 8;
  localparam int SRC_WAIT_T     = 9;
  localparam int SRC_CHAR_WAIT  = 10;
  localparam int SRC_BLOCK_WAIT = 11;
  localparam int SRC_INIT_CHAR  = 12;
  localparam int SRC_TX_THRESH  = 13;
  localparam int SRC_RX_THRESH  = 14;
  localparam int SRC_GUARD_VIOL = 15;

  typedef enum logic {
    POL_FALLING = 1'b0,
    POL_RISING  = 1'b1
  } edge_pol_e;

endpackage

// File: rtl/uart_edge_det.sv
module uart_edge_det #(
  parameter int SYNC_DEPTH = uart_irq_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  input  logic pol_i,
  input  logic two_wire_i,
  output logic edge_o
);
  import uart_irq_pkg::*;

  localparam int LAST = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  prev_q;
  logic                  lvl_now;
  logic                  lvl_prev;
  edge_pol_e             pol;

  // The synchronizer and the history bit start at the idle (high) level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[LAST-1:0], rxd_i};
      prev_q <= sync_q[LAST];
    end
  end

  // Fold the polarity in: a normalised level of 1 is the deasserted level.
  always_comb begin
    pol      = edge_pol_e'(pol_i);
    lvl_now  = (pol == POL_RISING) ? ~sync_q[LAST] : sync_q[LAST];
    lvl_prev = (pol == POL_RISING) ? ~prev_q       : prev_q;
    edge_o   = two_wire_i & lvl_prev & ~lvl_now;
  end

  AST_EDGE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (!edge_o || !$stable(pol_i))); // R10

endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
  parameter int N = uart_irq_pkg::NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> (flag_q[i] == $past(flag_q[i]))); // R2
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/uart_req_merge.sv
module uart_req_merge #(
  parameter int N     = uart_irq_pkg::NUM_SRC,
  parameter int TX_IX = uart_irq_pkg::SRC_TX_EMPTY,
  parameter int RX_IX = uart_irq_pkg::SRC_RX_FULL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  input  logic         tx_sel_i,
  input  logic         rx_sel_i,
  output logic         irq_o,
  output logic         wake_o,
  output logic         tx_dma_o,
  output logic         rx_dma_o
);

  logic [N-1:0] armed;
  logic [N-1:0] dma_mask;
  logic         irq_d, wake_d, txd_d, rxd_d;

  always_comb begin
    armed           = flag_i & en_i;
    dma_mask        = '0;
    dma_mask[TX_IX] = tx_sel_i;
    dma_mask[RX_IX] = rx_sel_i;
    irq_d           = |(armed & ~dma_mask);
    wake_d          = |armed;
    txd_d           = armed[TX_IX] & tx_sel_i;
    rxd_d           = armed[RX_IX] & rx_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      wake_o   <= 1'b0;
      tx_dma_o <= 1'b0;
      rx_dma_o <= 1'b0;
    end else begin
      irq_o    <= irq_d;
      wake_o   <= wake_d;
      tx_dma_o <= txd_d;
      rx_dma_o <= rxd_d;
    end
  end

  AST_WAKE_COVERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> wake_o); // R7
  AST_TX_DMA_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_o |-> $past(tx_sel_i)); // R5
  AST_RX_DMA_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_o |-> $past(rx_sel_i)); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(flag_i & en_i))); // R12

endmodule

// File: rtl/uart_irq_wake.sv
module uart_irq_wake #(
  parameter int N_SRC = uart_irq_pkg::NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] flag_set,
  input  logic [N_SRC-1:0] flag_clr,
  input  logic [N_SRC-1:0] flag_en,
  input  logic             tx_dma_sel,
  input  logic             rx_dma_sel,
  input  logic             edge_pol,
  input  logic             two_wire,
  input  logic             rxd,
  output logic [N_SRC-1:0] flags,
  output logic             irq,
  output logic             wake,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  import uart_irq_pkg::*;

  logic             edge_hit;
  logic [N_SRC-1:0] set_vec;

  uart_edge_det #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd_i      (rxd),
    .pol_i      (edge_pol),
    .two_wire_i (two_wire),
    .edge_o     (edge_hit)
  );

  // The edge flag is owned by the detector; the external pulse for it is dropped.
  always_comb begin
    set_vec              = flag_set;
    set_vec[SRC_RX_EDGE] = edge_hit;
  end

  uart_flag_bank #(.N(N_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  uart_req_merge #(.N(N_SRC), .TX_IX(SRC_TX_EMPTY), .RX_IX(SRC_RX_FULL)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_i   (flags),
    .en_i     (flag_en),
    .tx_sel_i (tx_dma_sel),
    .rx_sel_i (rx_dma_sel),
    .irq_o    (irq),
    .wake_o   (wake),
    .tx_dma_o (tx_dma_req),
    .rx_dma_o (rx_dma_req)
  );

  AST_EDGE_ONLY_TWO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[SRC_RX_EDGE]) |-> $past(two_wire)); // R9

endmodule

// File: tb/uart_irq_wake_test.sv
module uart_irq_wake_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] flag_set = '0, flag_clr = '0, flag_en = '0;
  logic         tx_dma_sel = 1'b0, rx_dma_sel = 1'b0;
  logic         edge_pol = 1'b0, two_wire = 1'b0, rxd = 1'b1;
  logic [W-1:0] flags;
  logic         irq, wake, tx_dma_req, rx_dma_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_wake uut (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
    .flag_en(flag_en), .tx_dma_sel(tx_dma_sel), .rx_dma_sel(rx_dma_sel),
    .edge_pol(edge_pol), .two_wire(two_wire), .rxd(rxd), .flags(flags),
    .irq(irq), .wake(wake), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [W-1:0] m);
    flag_set = m; step(1); flag_set = '0;
  endtask

  task automatic pulse_clr(input logic [W-1:0] m);
    flag_clr = m; step(1); flag_clr = '0;
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 flags in reset", flags, 0);
    chk("R1 outputs in reset", {irq, wake, tx_dma_req, rx_dma_req}, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 flags after reset", flags, 0);
    chk("R1 outputs after reset", {irq, wake, tx_dma_req, rx_dma_req}, 0);
  endtask

  task automatic t_sticky;
    flag_en = 16'h0020;
    pulse_set(16'h0020);
    chk("R2 flag set", flags, 16'h0020);
    chk("R4 irq not yet", irq, 0);
    step(1);
    chk("R4 irq one cycle later", irq, 1);
    step(3);
    chk("R2 flag held", flags, 16'h0020);
    flag_set = 16'h0020; flag_clr = 16'h0020; step(1);
    flag_set = '0; flag_clr = '0;
    chk("R2 set beats clear", flags, 16'h0020);
    pulse_clr(16'h0020);
    chk("R3 flag cleared", flags, 0);
    chk("R4 irq still high", irq, 1);
    step(1);
    chk("R4 irq falls", irq, 0);
    flag_en = '0;
  endtask

  task automatic t_clear_one;
    pulse_set(16'h00C0);
    chk("R2 two flags", flags, 16'h00C0);
    pulse_clr(16'h0040);
    chk("R3 only selected cleared", flags, 16'h0080);
    pulse_clr(16'h0080);
    chk("R3 all cleared", flags, 0);
  endtask

  task automatic t_disabled;
    flag_en = 16'hFEFF;
    pulse_set(16'h0100);
    step(2);
    chk("R12 flag visible", flags, 16'h0100);
    chk("R12 no requests", {irq, wake, tx_dma_req, rx_dma_req}, 0);
    pulse_clr(16'h0100);
    flag_en = '0;
  endtask

  task automatic t_tx_dma;
    flag_en = 16'h0001; tx_dma_sel = 1'b1;
    pulse_set(16'h0001);
    step(1);
    chk("R5 tx dma req", {irq, tx_dma_req, rx_dma_req}, 3'b010);
    chk("R7 wake with dma", wake, 1);
    tx_dma_sel = 1'b0; step(1);
    chk("R5 tx to irq", {irq, tx_dma_req}, 2'b10);
    pulse_clr(16'h0001); step(1);
    chk("R5 idle", {irq, wake, tx_dma_req}, 0);
    flag_en = '0;
  endtask

  task automatic t_rx_dma;
    flag_en = 16'h0008; rx_dma_sel = 1'b1;
    pulse_set(16'h0008);
    step(1);
    chk("R6 rx dma req", {irq, tx_dma_req, rx_dma_req}, 3'b001);
    chk("R7 wake with rx dma", wake, 1);
    rx_dma_sel = 1'b0; step(1);
    chk("R6 rx to irq", {irq, rx_dma_req, wake}, 3'b101);
    pulse_clr(16'h0008); step(1);
    chk("R6 idle", {irq, wake, rx_dma_req}, 0);
    flag_en = '0;
  endtask

  task automatic t_edge_fall;
    two_wire = 1'b1; edge_pol = 1'b0; flag_en = 16'h0010;
    rxd = 1'b0;
    step(2);
    chk("R8 not before sync", flags[4], 0);
    step(1);
    chk("R8 falling edge flag", flags[4], 1);
    step(1);
    chk("R8 edge irq", irq, 1);
    rxd = 1'b1; step(3);
    pulse_clr(16'h0010); step(1);
    chk("R8 cleared", {flags[4], irq}, 0);
  endtask

  task automatic t_edge_rise;
    edge_pol = 1'b1; step(4);
    chk("R10 line already asserted", flags[4], 0);
    rxd = 1'b0; step(4);
    chk("R8 falling ignored when rising", flags[4], 0);
    rxd = 1'b1; step(3);
    chk("R8 rising edge flag", flags[4], 1);
    pulse_clr(16'h0010);
    edge_pol = 1'b0; step(3);
    chk("R10 polarity change no edge", flags[4], 0);
  endtask

  task automatic t_one_wire;
    two_wire = 1'b0; rxd = 1'b0; step(4);
    chk("R9 no edge in one-wire", flags[4], 0);
    two_wire = 1'b1; step(3);
    chk("R10 held low no edge", flags[4], 0);
    rxd = 1'b1; step(3);
  endtask

  task automatic t_ext_set;
    pulse_set(16'h0010); step(2);
    chk("R11 external set ignored", flags, 0);
    chk("R11 no irq", irq, 0);
    flag_en = '0;
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_clear_one();
    t_disabled();
    t_tx_dma();
    t_rx_dma();
    t_edge_fall();
    t_edge_rise();
    t_one_wire();
    t_ext_set();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule